// File: doc/BRIEF.md
# RTC Status and Control Register Interface

This block is the byte-wide host-facing register front end for the four status/control registers of a real-time clock. These occupy four consecutive addresses starting at a parameterised base, 0x0A by default. The host presents an address, a write strobe with write data, or a read strobe. Read data is returned combinationally in the same cycle. The block keeps the configuration registers, decodes the time-base divider field, the interrupt rate field and the control bits, and drives the enable and select lines that the time counter and the periodic interrupt generator consume.

Register A at the base address holds the following fields:
- bit 7: an update-busy flag. The host cannot write it. It flips on every read.
- bits 6:4: the time-base divider code.
- bits 3:0: the interrupt rate code.

Register B at base+1 holds eight control bits. Only one combination of settings is implemented. Any write that asks for something else latches a sticky error flag, which only reset clears. Registers C and D at base+2 and base+3 accept writes and discard them.

Top module: `rtc_ctrl_regs`

## Requirements
- R1: After reset, register A reads with busy bit 0, divider bits 6:4 = 2 and rate bits 3:0 = 6. The read value is 0xA6, because the read itself flips the busy bit. Register B holds 0x42 (bit 6 periodic enable, bit 1 24-hour), with bit 2 (binary mode) copied from the `bin_strap_i` input, so it reads 0x46 when the strap is 1.
- R2: A write to register A updates bits 6:0 from the write data and leaves bit 7 (busy) at its previous value, whatever write data bit 7 is.
- R3: Each read of register A inverts the stored busy bit. The value returned during that read already carries the inverted bit, so two successive reads after reset return busy = 1 and then busy = 0.
- R4: A write to register B stores all eight bits. They read back unchanged, and reading B changes nothing.
- R5: A write to register A with a divider code other than 2 or a rate code other than 6 raises `unsup_o` on the next cycle.
- R6: A write to register B raises `unsup_o` on the next cycle if any of the following is true: bit 7 (stop updates), bit 5 (alarm interrupt), bit 4 (update-ended interrupt), bit 2 (binary mode) or bit 0 (daylight saving) is set, or bit 1 (24-hour) is clear. Bit 3 (square wave) and bit 6 (periodic enable) never raise it.
- R7: `unsup_o` is sticky. Later supported writes do not clear it, only reset does, and writes of supported values never set it.
- R8: Writes to registers C and D have no effect. Those addresses read 0, and registers A and B keep their contents.
- R9: `pie_en_o` equals register B bit 6 and changes in the cycle after a register B write.
- R10: `div_sel_o`, `rate_sel_o`, `sqw_en_o`, `bin_mode_o` and `hr24_o` mirror their register fields. `count_en_o` is low while B bit 7 is set. `osc_en_o` is low while the divider code is 6 or 7.
- R11: Reads of addresses outside the four registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bin_strap_i | input | 1 | Reset value of the binary-mode bit |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the read strobe |
| count_en_o | output | 1 | Time counter advance enable |
| osc_en_o | output | 1 | Time-base divider running |
| div_sel_o | output | 3 | Divider code |
| rate_sel_o | output | 4 | Periodic rate code |
| pie_en_o | output | 1 | Periodic interrupt generator enable |
| sqw_en_o | output | 1 | Square-wave output enable |
| bin_mode_o | output | 1 | Binary (not BCD) data mode |
| hr24_o | output | 1 | 24-hour format |
| unsup_o | output | 1 | Sticky unsupported-configuration flag |

## Verification
The following relations are checked by the bound properties on every cycle:
- The busy bit survives writes and flips on every read.
- Register B stores exactly what was written, and the periodic enable follows it one cycle later.
- Any unsupported field value sets the error flag, and the flag never falls.
- Writes to C and D leave A and B still.
- Out-of-range reads return zero.

Only the directed scenarios show the following:
- The absolute reset contents and the effect of the strap on them.
- The exact read values along a sequence of reads and writes.
- That supported writes leave the flag low.
- That reset alone clears the flag.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  localparam int DATA_W   = 8;
  localparam int DIV_W    = 3;
  localparam int RATE_W   = 4;
  localparam int N_STAT   = 4;

  localparam logic [DIV_W-1:0]  DIV_4M   = 3'd0;
  localparam logic [DIV_W-1:0]  DIV_1M   = 3'd1;
  localparam logic [DIV_W-1:0]  DIV_32K  = 3'd2;
  localparam logic [DIV_W-1:0]  DIV_OFF0 = 3'd6;
  localparam logic [DIV_W-1:0]  DIV_OFF1 = 3'd7;
  localparam logic [RATE_W-1:0] RATE_1K  = 4'd6;

  // register A: busy flag, divider code, rate code
  typedef struct packed {
    logic              busy;
    logic [DIV_W-1:0]  div;
    logic [RATE_W-1:0] rate;
  } stat_a_t;

  // register B: control bits, msb first
  typedef struct packed {
    logic halt;
    logic per_ie;
    logic alm_ie;
    logic upd_ie;
    logic sqw;
    logic bin;
    logic h24;
    logic dst;
  } stat_b_t;

  function automatic logic div_stopped(input logic [DIV_W-1:0] d);
    return (d == DIV_OFF0) || (d == DIV_OFF1);
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
  import rtc_regs_pkg::*;
#(
  parameter int                 ADDR_W = 8,
  parameter logic [ADDR_W-1:0]  A_ADDR = 8'h0A
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [N_STAT-1:0] hit_o,
  output logic              wr_a_o,
  output logic              wr_b_o,
  output logic              rd_a_o
);
  for (genvar g = 0; g < N_STAT; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(g);
    assign hit_o[g] = (addr_i == (A_ADDR + OFS));
  end

  assign wr_a_o = wr_en_i & hit_o[0];
  assign wr_b_o = wr_en_i & hit_o[1];
  assign rd_a_o = rd_en_i & hit_o[0];
endmodule

// File: rtl/rtc_stat_a.sv
module rtc_stat_a
  import rtc_regs_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [DIV_W+RATE_W-1:0] wfield_i,
  output stat_a_t                 q_o
);
  stat_a_t q, d;
  logic    en;

  always_comb begin
    d  = q;
    en = wr_i | rd_i;
    if (wr_i) {d.div, d.rate} = wfield_i;
    if (rd_i) d.busy = ~q.busy;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= '{busy: 1'b0, div: DIV_32K, rate: RATE_1K};
    else if (en)  q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/rtc_stat_b.sv
module rtc_stat_b
  import rtc_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bin_strap_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output stat_b_t           q_o
);
  stat_b_t q, d, rst_val;

  always_comb begin
    rst_val        = '0;
    rst_val.per_ie = 1'b1;
    rst_val.h24    = 1'b1;
    rst_val.bin    = bin_strap_i;
    d              = stat_b_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= rst_val;
    else if (wr_i) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/rtc_unsup_chk.sv
module rtc_unsup_chk
  import rtc_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              flag_o
);
  stat_a_t wa;
  stat_b_t wb;
  logic    bad_a, bad_b, flag_d, flag_q;

  always_comb begin
    wa     = stat_a_t'(wdata_i);
    wb     = stat_b_t'(wdata_i);
    bad_a  = (wa.div != DIV_32K) | (wa.rate != RATE_1K);
    bad_b  = wb.halt | wb.alm_ie | wb.upd_ie | wb.bin | wb.dst | ~wb.h24;
    flag_d = flag_q | (wr_a_i & bad_a) | (wr_b_i & bad_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] A_ADDR    = 8'h0A,
  parameter int                RST_SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bin_strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              count_en_o,
  output logic              osc_en_o,
  output logic [2:0]        div_sel_o,
  output logic [3:0]        rate_sel_o,
  output logic              pie_en_o,
  output logic              sqw_en_o,
  output logic              bin_mode_o,
  output logic              hr24_o,
  output logic              unsup_o
);
  logic              rst_n_sync;
  logic [N_STAT-1:0] hit;
  logic              wr_a, wr_b, rd_a;
  stat_a_t           rega_q;
  stat_b_t           regb_q;

  rtc_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n_sync)
  );

  rtc_reg_decode #(.ADDR_W(ADDR_W), .A_ADDR(A_ADDR)) u_dec (
    .addr_i (addr_i), .wr_en_i (wr_en_i), .rd_en_i (rd_en_i),
    .hit_o (hit), .wr_a_o (wr_a), .wr_b_o (wr_b), .rd_a_o (rd_a)
  );

  rtc_stat_a u_rega (
    .clk_i (clk_i), .rst_ni (rst_n_sync), .wr_i (wr_a), .rd_i (rd_a),
    .wfield_i (wdata_i[DIV_W+RATE_W-1:0]), .q_o (rega_q)
  );

  rtc_stat_b u_regb (
    .clk_i (clk_i), .rst_ni (rst_n_sync), .bin_strap_i (bin_strap_i),
    .wr_i (wr_b), .wdata_i (wdata_i), .q_o (regb_q)
  );

  rtc_unsup_chk u_unsup (
    .clk_i (clk_i), .rst_ni (rst_n_sync), .wr_a_i (wr_a), .wr_b_i (wr_b),
    .wdata_i (wdata_i), .flag_o (unsup_o)
  );

  // read mux: the busy bit leaves already inverted during a read of A
  always_comb begin
    case (hit)
      4'b0001: rdata_o = {rega_q.busy ^ rd_a, rega_q.div, rega_q.rate};
      4'b0010: rdata_o = regb_q;
      default: rdata_o = '0;
    endcase
  end

  assign count_en_o = ~regb_q.halt;
  assign osc_en_o   = ~div_stopped(rega_q.div);
  assign div_sel_o  = rega_q.div;
  assign rate_sel_o = rega_q.rate;
  assign pie_en_o   = regb_q.per_ie;
  assign sqw_en_o   = regb_q.sqw;
  assign bin_mode_o = regb_q.bin;
  assign hr24_o     = regb_q.h24;
endmodule

// File: rtl/rtc_ctrl_regs_chk.sv
module rtc_ctrl_regs_chk
  import rtc_regs_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_ADDR = 8'h0A
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              count_en_o,
  input logic              osc_en_o,
  input logic              pie_en_o,
  input logic              unsup_o,
  input stat_a_t           rega_q,
  input stat_b_t           regb_q
);
  logic [ADDR_W-1:0] rel;
  logic at_a, at_b, at_cd;
  assign rel   = addr_i - A_ADDR;
  assign at_a  = (rel == ADDR_W'(0));
  assign at_b  = (rel == ADDR_W'(1));
  assign at_cd = (rel == ADDR_W'(2)) || (rel == ADDR_W'(3));

  a_r2_busy_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_a && !rd_en_i) |=> rega_q.busy == $past(rega_q.busy));

  a_r3_busy_flip: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && at_a) |=> rega_q.busy != $past(rega_q.busy));

  a_r4_b_store: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_b) |=> regb_q == $past(wdata_i));

  a_r5_bad_a: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_a && (wdata_i[6:4] != 3'd2 || wdata_i[3:0] != 4'd6))
    |=> unsup_o);

  a_r6_bad_b: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_b && (wdata_i[7] || wdata_i[5] || wdata_i[4] ||
                         wdata_i[2] || wdata_i[0] || !wdata_i[1]))
    |=> unsup_o);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    unsup_o |=> unsup_o);

  a_r8_cd_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_cd && !rd_en_i) |=> ($stable(rega_q) && $stable(regb_q)));

  a_r9_pie_follow: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && at_b) |=> pie_en_o == $past(wdata_i[6]));

  a_r10_halt: assert property (@(posedge clk_i) disable iff (!rst_n)
    regb_q.halt |-> !count_en_o);

  a_r10_osc_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rega_q.div == 3'd6 || rega_q.div == 3'd7) |-> !osc_en_o);

  a_r11_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && (rel > ADDR_W'(3))) |-> rdata_o == 8'h00);
endmodule

bind rtc_ctrl_regs rtc_ctrl_regs_chk #(.ADDR_W(ADDR_W), .A_ADDR(A_ADDR)) u_chk (
  .clk_i (clk_i), .rst_n (rst_n_sync), .addr_i (addr_i), .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
  .count_en_o (count_en_o), .osc_en_o (osc_en_o), .pie_en_o (pie_en_o),
  .unsup_o (unsup_o), .rega_q (rega_q), .regb_q (regb_q)
);

// File: tb/sim_rtc_ctrl_regs.sv
module sim_rtc_ctrl_regs;
  localparam int CLK_P = 10;
  localparam logic [7:0] RA = 8'h0A, RB = 8'h0B, RC = 8'h0C, RD = 8'h0D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic [7:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       count_en, osc_en, pie_en, sqw_en, bin_mode, hr24, unsup;
  logic [2:0] div_sel;
  logic [3:0] rate_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_ctrl_regs u0 (
    .clk_i (clk), .rst_ni (rst_n), .bin_strap_i (strap), .addr_i (addr),
    .wr_en_i (wr), .rd_en_i (rd), .wdata_i (wdata), .rdata_o (rdata),
    .count_en_o (count_en), .osc_en_o (osc_en), .div_sel_o (div_sel),
    .rate_sel_o (rate_sel), .pie_en_o (pie_en), .sqw_en_o (sqw_en),
    .bin_mode_o (bin_mode), .hr24_o (hr24), .unsup_o (unsup)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0; wr = 0; rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #(CLK_P/4);
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset_vals;
    logic [7:0] v;
    do_reset(1'b0);
    chk("R7 flag low after reset", unsup, 0);
    rd_reg(RB, v); chk("R1 B reset", v, 8'h42);
    rd_reg(RA, v); chk("R1 A reset (busy flipped by read)", v, 8'hA6);
    chk("R10 div/rate at reset", {div_sel, rate_sel}, {3'd2, 4'd6});
    chk("R10 enables at reset", {count_en, osc_en, pie_en, hr24, bin_mode, sqw_en}, 6'b111100);
    do_reset(1'b1);
    rd_reg(RB, v); chk("R1 B reset with strap", v, 8'h46);
    chk("R10 bin mode from strap", bin_mode, 1);
    chk("R7 strap does not raise flag", unsup, 0);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    do_reset(1'b0);
    rd_reg(RA, v); chk("R3 first read busy=1", v, 8'hA6);
    rd_reg(RA, v); chk("R3 second read busy=0", v, 8'h26);
    wr_reg(RA, 8'hA6);               // busy stored 0, data tries 1
    rd_reg(RA, v); chk("R2 write keeps busy=0", v, 8'hA6);
    wr_reg(RA, 8'h26);               // busy stored 1, data tries 0
    rd_reg(RA, v); chk("R2 write keeps busy=1", v, 8'h26);
    chk("R7 supported A writes keep flag low", unsup, 0);
  endtask

  task automatic t_regb_pie;
    logic [7:0] v;
    do_reset(1'b0);
    @(negedge clk);
    addr = RB; wdata = 8'h0A; wr = 1'b1;
    #(CLK_P/4);
    chk("R9 pie unchanged before edge", pie_en, 1);
    @(negedge clk);
    wr = 1'b0;
    chk("R9 pie off cycle after write", pie_en, 0);
    chk("R10 square wave on", sqw_en, 1);
    rd_reg(RB, v); chk("R4 B readback", v, 8'h0A);
    rd_reg(RB, v); chk("R4 B read has no effect", v, 8'h0A);
    chk("R6 square wave/pie clear supported", unsup, 0);
    wr_reg(RB, 8'h42);
    chk("R9 pie back on", pie_en, 1);
  endtask

  task automatic t_unsup_a;
    logic [7:0] v;
    do_reset(1'b0);
    wr_reg(RA, 8'h16);
    chk("R5 divider 1 flagged", unsup, 1);
    chk("R10 div select mirrors", div_sel, 3'd1);
    wr_reg(RA, 8'h26);
    wr_reg(RB, 8'h42);
    chk("R7 flag stays after supported writes", unsup, 1);
    do_reset(1'b0);
    chk("R7 reset clears flag", unsup, 0);
    wr_reg(RA, 8'h27);
    chk("R5 rate 7 flagged", unsup, 1);
    chk("R10 rate select mirrors", rate_sel, 4'd7);
    wr_reg(RA, 8'h66);
    chk("R10 divider 6 stops osc", osc_en, 0);
    wr_reg(RA, 8'h76);
    chk("R10 divider 7 stops osc", osc_en, 0);
    wr_reg(RA, 8'h06);
    chk("R10 divider 0 runs osc", osc_en, 1);
    rd_reg(RA, v); chk("R2 fields stored", v[6:0], 7'h06);
  endtask

  task automatic t_unsup_b;
    logic [7:0] bad [6] = '{8'hC2, 8'h62, 8'h52, 8'h46, 8'h40, 8'h43};
    for (int i = 0; i < 6; i++) begin
      do_reset(1'b0);
      wr_reg(RB, bad[i]);
      chk($sformatf("R6 B value %0h flagged", bad[i]), unsup, 1);
    end
    do_reset(1'b0);
    wr_reg(RB, 8'hC2);
    chk("R10 halt stops counter", count_en, 0);
    wr_reg(RB, 8'h40);
    chk("R10 12-hour mirrors", hr24, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    do_reset(1'b0);
    wr_reg(RC, 8'hFF);
    wr_reg(RD, 8'hFF);
    rd_reg(RC, v); chk("R8 C reads 0", v, 0);
    rd_reg(RD, v); chk("R8 D reads 0", v, 0);
    rd_reg(RB, v); chk("R8 B untouched", v, 8'h42);
    rd_reg(RA, v); chk("R8 A untouched", v, 8'hA6);
    chk("R8 no flag from C/D", unsup, 0);
    rd_reg(8'h00, v); chk("R11 addr 0 reads 0", v, 0);
    rd_reg(8'h0E, v); chk("R11 addr 0E reads 0", v, 0);
    rd_reg(8'h09, v); chk("R11 addr 09 reads 0", v, 0);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset_vals();
    t_busy();
    t_regb_pie();
    t_unsup_a();
    t_unsup_b();
    t_ignored();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule